// File: doc/BRIEF.md
# Synchronous Burst SRAM Write-Control Core

This block is a clock-accurate model of a flow-through synchronous burst SRAM. It holds an 18-bit-wide storage array of `2**ADDR_W` words. It registers a burst start address from either of two address strobes, steps that address through an aligned group of four, and writes whole words or single 9-bit lanes according to a global-write input, a byte-write enable and one strobe per lane. Reads are flow-through. The word at the registered address comes straight out of the array in the same cycle, with no output register.

The processor-side strobe loads an address and blocks every write in its load cycle. The controller-side strobe loads an address and may write to it at once. That lets a controller restart or extend a write burst without a dead cycle. The advance input steps the burst. When advance is held inactive, the burst stalls on its current word. The data path is split into `din`, `dout` and a drive flag `dout_en` that stands in for the tri-state output. This is a plain synchronous control interface with no valid/ready handshake. Every input is sampled on each rising edge, and the block never stalls its caller.

Top module: `burst_sram_core`

## Requirements
- R1: The core is selected only when `en1_n`=0, `en2_n`=0 and `en3`=1. In any other combination, no address is loaded, no write occurs, the registered address holds and `dout_en` is 0.
- R2: When the core is selected and `proc_strobe_n` or `ctrl_strobe_n` is 0 at a rising edge, `addr` becomes the registered address. After that edge, a read returns the word stored at `addr`.
- R3: In a cycle with `proc_strobe_n`=0, no lane is written, whatever the values of `gw_n`, `bwe_n` and `bw_n`.
- R4: In a selected cycle with `ctrl_strobe_n`=0 and `proc_strobe_n`=1, the write inputs act on the newly loaded address. This also holds in the middle of a burst, where the burst restarts at the new address.
- R5: In a selected cycle with no load and `adv_n`=0, bits [1:0] of the registered address increment by one and wrap from 3 to 0 (linear order). The upper bits stay fixed, and any write in that cycle goes to the advanced address.
- R6: In a selected cycle with no load and `adv_n`=1, the registered address holds, and any write in that cycle goes to the held address.
- R7: `gw_n`=0 writes all 18 bits.
- R8: `gw_n`=1 with `bwe_n`=0 and `bw_n`=2'b00 writes all 18 bits.
- R9: With `gw_n`=1 and `bwe_n`=0, `bw_n[0]`=0 writes bits [8:0] and `bw_n[1]`=0 writes bits [17:9]. A lane whose strobe is 1 keeps its old contents.
- R10: With `gw_n`=1 and `bwe_n`=1, no lane is written.
- R11: `dout_en` is 1 only when the core is selected, `oe_n`=0 and no lane is being written in that cycle. When `dout_en` is 1, `dout` shows the word at the registered address, read combinationally. Otherwise `dout` is 0.
- R12: Reset clears the registered address to 0. It does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the address register |
| addr | input | ADDR_W | Burst start address |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, no write in its load cycle |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| en1_n | input | 1 | Select input, active low |
| en2_n | input | 1 | Select input, active low |
| en3 | input | 1 | Select input, active high |
| gw_n | input | 1 | Global full-width write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write strobes, active low (bit 0: bits 8:0, bit 1: bits 17:9) |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, 0 when not driven |
| dout_en | output | 1 | Output drive flag, stands in for the tri-state output |

## Verification
The embedded assertions check the following on every cycle:
- the address register's behaviour under load, advance, stall and deselect, including the wrap of the low two bits with the upper bits fixed;
- the suppression of writes under the processor-side strobe and under an inactive byte-write enable;
- the rule that output drive is never on while `oe_n` is high, while the core is deselected or while a lane is being written.

Only the bench's scenarios can show that the right data lands in the right lane at the right address and is read back:
- every combination of the global-write, byte-write-enable and lane-strobe inputs is swept against a reference array;
- write and read bursts wrap within an aligned group of four, stall mid-burst and restart mid-burst on the controller strobe;
- every non-selecting chip-enable combination is tried;
- the array is shown to survive a reset.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int LANE_W  = 9;
  localparam int LANES   = 2;
  localparam int WORD_W  = LANE_W * LANES;
  localparam int BURST_W = 2;
endpackage

// File: rtl/sbw_wr_decode.sv
module sbw_wr_decode
  import sbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             proc_ld_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we
);

  always_comb begin
    lane_we = '0;
    if (sel && proc_ld_n) begin
      if (!gw_n)       lane_we = '1;
      else if (!bwe_n) lane_we = ~bw_n;
    end
  end

  assert_proc_load_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_ld_n |-> lane_we == '0);

  assert_global_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && proc_ld_n && !gw_n) |-> &lane_we);

  assert_bwe_off_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> lane_we == '0);

endmodule

// File: rtl/sbw_burst_addr.sv
module sbw_burst_addr
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              load,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  always_comb begin
    nxt_addr = cur_addr;
    if (load)
      nxt_addr = ld_addr;
    else if (sel && !adv_n)
      nxt_addr = {cur_addr[ADDR_W-1:BURST_W], cur_addr[BURST_W-1:0] + BURST_W'(1)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_addr <= '0;
    else        cur_addr <= nxt_addr;
  end

  assert_load_takes_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_addr == $past(ld_addr));

  assert_suspend_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !load && adv_n) |=> $stable(cur_addr));

  assert_advance_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !load && !adv_n) |=>
      (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])) &&
      (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)));

  assert_deselect_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(cur_addr));

endmodule

// File: rtl/sbw_lane_array.sv
module sbw_lane_array
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              en1_n,
  input  logic              en2_n,
  input  logic              en3,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  logic              sel;
  logic              load;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] rdata;

  assign sel  = !en1_n && !en2_n && en3;
  assign load = sel && (!proc_strobe_n || !ctrl_strobe_n);

  sbw_wr_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .proc_ld_n (proc_strobe_n),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .bw_n      (bw_n),
    .lane_we   (lane_we)
  );

  sbw_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .load     (load),
    .adv_n    (adv_n),
    .ld_addr  (addr),
    .nxt_addr (nxt_addr),
    .cur_addr (cur_addr)
  );

  sbw_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (lane_we),
    .waddr (nxt_addr),
    .wdata (din),
    .raddr (cur_addr),
    .rdata (rdata)
  );

  assign dout_en = sel && !oe_n && (lane_we == '0);
  assign dout    = dout_en ? rdata : '0;

  assert_oe_high_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  assert_write_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !dout_en);

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!dout_en && lane_we == '0));

endmodule

// File: tb/test_burst_sram_core.sv
module test_burst_sram_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          p_n = 1'b1, c_n = 1'b1, adv_n = 1'b1;
  logic          e1_n = 1'b1, e2_n = 1'b1, e3 = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
  logic [1:0]    bw_n = 2'b11;
  logic [17:0]   din = '0;
  logic [17:0]   dout;
  logic          dout_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [17:0]   m [DEPTH];
  logic [AW-1:0] ba_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_core #(.ADDR_W(AW)) i_burst_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_strobe_n(p_n), .ctrl_strobe_n(c_n), .adv_n(adv_n),
    .en1_n(e1_n), .en2_n(e2_n), .en3(e3),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(int k);
    return 18'(k * 1217) ^ 18'h15A3C;
  endfunction

  // One cycle: drive at negedge, check combinational outputs, then update the model at the edge.
  task automatic step(input string tag, input logic [2:0] ce, input logic sp, input logic sc,
                      input logic av, input logic g, input logic be, input logic [1:0] b,
                      input logic oe, input logic [AW-1:0] a, input logic [17:0] d);
    logic sel;
    logic [1:0] lanes;
    logic exp_en;
    logic [17:0] exp_d;
    logic [AW-1:0] nb;
    @(negedge clk);
    {e1_n, e2_n, e3} = ce;
    p_n = sp; c_n = sc; adv_n = av; gw_n = g; bwe_n = be; bw_n = b; oe_n = oe; addr = a; din = d;
    #1;
    sel   = !ce[2] && !ce[1] && ce[0];
    lanes = 2'b00;
    if (sel && sp) lanes = !g ? 2'b11 : (!be ? ~b : 2'b00);
    exp_en = sel && !oe && (lanes == 2'b00);
    exp_d  = exp_en ? m[ba_m] : 18'h0;
    checks++;
    if (dout_en !== exp_en) begin
      fails++;
      $display("FAIL %s dout_en actual=%b expected=%b", tag, dout_en, exp_en);
    end
    checks++;
    if (dout !== exp_d) begin
      fails++;
      $display("FAIL %s dout actual=%h expected=%h", tag, dout, exp_d);
    end
    @(posedge clk);
    nb = ba_m;
    if (sel) begin
      if (!sp || !sc)  nb = a;
      else if (!av)    nb = {ba_m[AW-1:2], 2'(ba_m[1:0] + 2'd1)};
      if (lanes[0]) m[nb][8:0]  = d[8:0];
      if (lanes[1]) m[nb][17:9] = d[17:9];
    end
    ba_m = nb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    {e1_n, e2_n, e3} = 3'b110;
    p_n = 1'b1; c_n = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ba_m = '0;
  endtask

  localparam logic [2:0] SEL = 3'b001;

  initial begin
    string t;
    do_reset();
    // R4 R7: fill every word through the controller strobe with a global write; oe_n high (R11)
    for (int a = 0; a < DEPTH; a++)
      step("R4", SEL, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, AW'(a), pat(a));
    // R2 R3: load every address with the processor strobe while all writes are requested, then read
    for (int a = 0; a < DEPTH; a++) begin
      step("R3", SEL, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, AW'(a), 18'h3FFFF);
      step("R2", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, 18'h0);
    end
    // R6 R7 R8 R9 R10: sweep every write-control combination at the held address
    for (int code = 0; code < 16; code++) begin
      if (code[3] == 0)         t = "R7";
      else if (code[2] == 1)    t = "R10";
      else if (code[1:0] == 0)  t = "R8";
      else                      t = "R9";
      step("R3", SEL, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 4'd5, 18'h0);
      step("R6", SEL, 1'b1, 1'b1, 1'b1, code[3], code[2], 2'(code[1:0]), 1'b1, 4'd0, pat(100 + code));
      step(t, SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
    end
    // R5: write burst from 6 wraps 6,7,4,5 with a stall in the middle
    step("R4", SEL, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 4'd6, pat(200));
    step("R5", SEL, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'd0, pat(201));
    step("R6", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 4'd0, 18'h0);
    step("R5", SEL, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'd0, pat(202));
    step("R5", SEL, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 4'd0, pat(203));
    // R4: controller strobe mid-burst restarts at 9 and writes there
    step("R4", SEL, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'd9, pat(204));
    step("R5", SEL, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'd0, pat(205));
    // R5: read bursts from 6 and from 11 (wrap to 8), each through five beats
    for (int s = 0; s < 2; s++) begin
      step("R2", SEL, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, (s == 0) ? 4'd6 : 4'd11, 18'h0);
      for (int k = 0; k < 5; k++)
        step("R5", SEL, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
      step("R6", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
    end
    // R1: every non-selecting enable combination tries a load, an advance and a full write
    for (int ce = 0; ce < 8; ce++) begin
      if (ce == 1) continue;
      step("R1", 3'(ce), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd12, pat(300 + ce));
      step("R1", 3'(ce), 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 4'd0, pat(310 + ce));
      step("R1", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
    end
    step("R1", SEL, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd12, 18'h0);
    step("R1", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
    // R11: a selected read with oe_n high must not drive
    step("R11", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 4'd0, 18'h0);
    // R12: reset away from address 0; the address returns to 0 and the array is kept
    step("R12", SEL, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 4'd13, 18'h0);
    do_reset();
    step("R12", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
    step("R12", SEL, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd13, 18'h0);
    step("R12", SEL, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, 18'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule